// File: doc/BRIEF.md
# Maskable BCD Time-of-Day Alarm

This block holds three alarm bytes (minutes, hours, day of week) and compares them with the running BCD time. The time itself comes from a separate counter. A comparison counts only in the cycle that a seconds-wrap strobe is high. That strobe marks the instant the seconds count passes from 59 back to 00, so a matching minute gives one alarm event and not a continuous condition.

Bit 7 of each alarm byte is a don't-care marker that removes its field from the comparison. Masking the day gives a daily alarm. Masking day and hours gives an hourly alarm. Masking all three gives an alarm at every minute boundary.

An alarm event sets a sticky flag, which is also the internal time-of-day interrupt. The active-low interrupt pin follows the flag only when two command inputs allow it: the source switch must select the time-of-day source, and the time-of-day mask must be clear. Any bus read or bus write to one of the alarm bytes clears the flag. That also clears the interrupt and releases the pin.

Top module: `tod_alarm_unit`

## Requirements
- R1: After synchronous reset, all three alarm bytes hold 00h, `tod_flag` is 0, `int_n` is 1 and `bus_rdata` is 00h.
- R2: A write (`bus_sel`=1, `bus_wr`=1) to address 3 (minutes), 5 (hours) or 7 (day) stores `bus_wdata` at the clock edge. A read (`bus_sel`=1, `bus_wr`=0) of the same address returns the stored byte on `bus_rdata` in the same cycle.
- R3: The day byte always reads bits 6 to 3 as 0, whatever was written. Any cycle that is not a read of address 3, 5 or 7 returns 00h on `bus_rdata`.
- R4: A match is evaluated only when `sec_wrap` is 1. A matching time without the strobe never sets the flag. A match with the strobe sets `tod_flag` at that clock edge.
- R5: An alarm byte with bit 7 = 1 is excluded from the match. With day masked the alarm is daily, with day and hours masked it is hourly, and with all three masked it fires at every strobe.
- R6: Minutes and hours compare bits 6 to 0 of the alarm byte against the time input. Day compares only bits 2 to 0. Time-input bits outside those ranges have no effect.
- R7: `tod_flag` stays set across strobes and bus traffic until an alarm byte is accessed.
- R8: Any read or write of address 3, 5 or 7 clears `tod_flag` at that clock edge. Accesses to other addresses leave it unchanged. An alarm event in the same cycle as such an access leaves the flag set.
- R9: `int_n` is 0 exactly when `tod_flag` = 1, `irq_sel_wdog` = 0 and `tod_irq_mask` = 0; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus cycle valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_day | input | 8 | Current day of week |
| sec_wrap | input | 1 | Seconds 59-to-00 strobe |
| irq_sel_wdog | input | 1 | Interrupt source switch, 0 = time-of-day |
| tod_irq_mask | input | 1 | Time-of-day interrupt mask, 1 = blocked |
| tod_flag | output | 1 | Sticky alarm flag, also the internal interrupt |
| int_n | output | 1 | Interrupt pin, active low |

## Verification
The bench builds the block with its default parameters: a 4-bit address and alarm bytes at 3, 5 and 7. That address space is small enough for random traffic to hit every non-alarm address. This shows that those addresses read 00h and never clear the flag. The time inputs are drawn so that the masked and unmasked fields match often. This brings the daily, hourly and per-minute rates, and the same-cycle event/access collision, within reach of both the directed and the random phases.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MH_CMP  = 8'h7F;
  localparam logic [BYTE_W-1:0] DAY_CMP = 8'h07;
  localparam logic [BYTE_W-1:0] DAY_KEEP = 8'h87;

  // A field matches when its don't-care bit is set or the compared bits agree.
  function automatic logic field_hit(input logic [BYTE_W-1:0] alarm,
                                     input logic [BYTE_W-1:0] now,
                                     input logic [BYTE_W-1:0] cmp);
    return alarm[BYTE_W-1] | ((alarm & cmp) == (now & cmp));
  endfunction

  // Day byte keeps the mask bit and the three day bits only.
  function automatic logic [BYTE_W-1:0] day_store(input logic [BYTE_W-1:0] w);
    return w & DAY_KEEP;
  endfunction
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MIN_ADDR  = 3,
  parameter int HOUR_ADDR = 5,
  parameter int DAY_ADDR  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] al_min,
  output logic [BYTE_W-1:0] al_hour,
  output logic [BYTE_W-1:0] al_day,
  output logic              al_access
);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(MIN_ADDR);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(HOUR_ADDR);
  localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(DAY_ADDR);

  logic sel_min, sel_hour, sel_day;
  logic wr_min, wr_hour, wr_day, rd_en;

  assign sel_min   = bus_sel && (bus_addr == A_MIN);
  assign sel_hour  = bus_sel && (bus_addr == A_HOUR);
  assign sel_day   = bus_sel && (bus_addr == A_DAY);
  assign wr_min    = sel_min  && bus_wr;
  assign wr_hour   = sel_hour && bus_wr;
  assign wr_day    = sel_day  && bus_wr;
  assign rd_en     = !bus_wr;
  assign al_access = sel_min || sel_hour || sel_day;

  always_ff @(posedge clk) begin
    if (rst) begin
      al_min  <= '0;
      al_hour <= '0;
      al_day  <= '0;
    end else begin
      if (wr_min)  al_min  <= bus_wdata;
      if (wr_hour) al_hour <= bus_wdata;
      if (wr_day)  al_day  <= day_store(bus_wdata);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (sel_min)       bus_rdata = al_min;
      else if (sel_hour) bus_rdata = al_hour;
      else if (sel_day)  bus_rdata = al_day;
    end
  end

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_min |=> (al_min == $past(bus_wdata)));
  // R3
  day_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_day && !bus_wr) |-> (bus_rdata[6:3] == 4'd0));
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] al_min,
  input  logic [BYTE_W-1:0] al_hour,
  input  logic [BYTE_W-1:0] al_day,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [BYTE_W-1:0] cur_day,
  input  logic              sec_wrap,
  output logic              alarm_evt
);
  logic min_hit, hour_hit, day_hit, all_hit;

  assign min_hit   = field_hit(al_min,  cur_min,  MH_CMP);
  assign hour_hit  = field_hit(al_hour, cur_hour, MH_CMP);
  assign day_hit   = field_hit(al_day,  cur_day,  DAY_CMP);
  assign all_hit   = min_hit && hour_hit && day_hit;
  assign alarm_evt = sec_wrap && all_hit;

  // R5
  every_minute_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_wrap && al_min[7] && al_hour[7] && al_day[7]) |-> alarm_evt);
  // R4
  strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_wrap |-> !alarm_evt);
endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq (
  input  logic clk,
  input  logic rst,
  input  logic alarm_evt,
  input  logic al_access,
  input  logic irq_sel_wdog,
  input  logic tod_irq_mask,
  output logic tod_flag,
  output logic int_n
);
  logic pin_drive;

  always_ff @(posedge clk) begin
    if (rst)            tod_flag <= 1'b0;
    else if (alarm_evt) tod_flag <= 1'b1;
    else if (al_access) tod_flag <= 1'b0;
  end

  assign pin_drive = tod_flag && !irq_sel_wdog && !tod_irq_mask;
  assign int_n     = !pin_drive;

  // R4
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_evt |=> tod_flag);
  // R8
  access_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (al_access && !alarm_evt) |=> !tod_flag);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!alarm_evt && !al_access) |=> $stable(tod_flag));
  // R9
  pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_sel_wdog || tod_irq_mask || !tod_flag) |-> int_n);
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MIN_ADDR  = 3,
  parameter int HOUR_ADDR = 5,
  parameter int DAY_ADDR  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_day,
  input  logic              sec_wrap,
  input  logic              irq_sel_wdog,
  input  logic              tod_irq_mask,
  output logic              tod_flag,
  output logic              int_n
);
  logic [BYTE_W-1:0] al_min, al_hour, al_day;
  logic al_access, alarm_evt;

  tod_alarm_regs #(
    .ADDR_W(ADDR_W), .MIN_ADDR(MIN_ADDR), .HOUR_ADDR(HOUR_ADDR), .DAY_ADDR(DAY_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .al_min(al_min), .al_hour(al_hour),
    .al_day(al_day), .al_access(al_access)
  );

  tod_alarm_match u_match (
    .clk(clk), .rst(rst), .al_min(al_min), .al_hour(al_hour), .al_day(al_day),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .sec_wrap(sec_wrap), .alarm_evt(alarm_evt)
  );

  tod_alarm_irq u_irq (
    .clk(clk), .rst(rst), .alarm_evt(alarm_evt), .al_access(al_access),
    .irq_sel_wdog(irq_sel_wdog), .tod_irq_mask(tod_irq_mask),
    .tod_flag(tod_flag), .int_n(int_n)
  );

  // R1
  reset_flag_chk: assert property (@(posedge clk) rst |=> !tod_flag);
endmodule

// File: tb/tb_tod_alarm_unit.sv
`timescale 1ns/100ps
module tb_tod_alarm_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] cur_min = 0, cur_hour = 0, cur_day = 0;
  logic sec_wrap = 0, irq_sel_wdog = 0, tod_irq_mask = 0;
  logic tod_flag, int_n;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tod_alarm_unit dut (.*);

  // Reference model state
  int m_min = 0, m_hr = 0, m_day = 0;
  bit m_flag = 0;

  function automatic bit ref_mh(int a, int c);
    return (a >= 128) || ((a % 128) == (c % 128));
  endfunction
  function automatic bit ref_day(int a, int c);
    return (a >= 128) || ((a % 8) == (c % 8));
  endfunction
  function automatic bit is_alarm_addr(int a);
    return a == 3 || a == 5 || a == 7;
  endfunction

  always @(posedge clk) begin
    bit ev, ac;
    if (rst) begin
      m_min <= 0; m_hr <= 0; m_day <= 0; m_flag <= 0;
    end else begin
      ev = sec_wrap && ref_mh(m_min, cur_min) && ref_mh(m_hr, cur_hour) && ref_day(m_day, cur_day);
      ac = bus_sel && is_alarm_addr(bus_addr);
      if (bus_sel && bus_wr) begin
        if (bus_addr == 3) m_min <= bus_wdata;
        if (bus_addr == 5) m_hr  <= bus_wdata;
        if (bus_addr == 7) m_day <= (bus_wdata / 128) * 128 + (bus_wdata % 8);
      end
      if (ev) m_flag <= 1;
      else if (ac) m_flag <= 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    int exp_rd;
    if (!rst && !done) begin
      exp_rd = 0;
      if (bus_sel && !bus_wr) begin
        if (bus_addr == 3) exp_rd = m_min;
        else if (bus_addr == 5) exp_rd = m_hr;
        else if (bus_addr == 7) exp_rd = m_day;
      end
      chk("R7 flag vs model", tod_flag, m_flag);
      chk("R9 int_n vs model", int_n, !(m_flag && !irq_sel_wdog && !tod_irq_mask));
      chk("R2 rdata vs model", bus_rdata, exp_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; sec_wrap = 0;
  endtask
  task automatic wr(int a, int d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d); sec_wrap = 0;
  endtask
  task automatic rd(int a, int exp, string req);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = 4'(a); sec_wrap = 0;
    #1 chk(req, bus_rdata, exp);
  endtask
  task automatic tick(int mn, int hr, int dy);
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; cur_min = 8'(mn); cur_hour = 8'(hr); cur_day = 8'(dy); sec_wrap = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    // R1 reset state
    chk("R1 flag after reset", tod_flag, 0);
    chk("R1 int_n after reset", int_n, 1);
    chk("R1 rdata after reset", bus_rdata, 0);
    rd(3, 0, "R1 minutes byte reset");
    rd(5, 0, "R1 hours byte reset");
    rd(7, 0, "R1 day byte reset");

    // R2 / R3 store and readback
    wr(3, 8'h30); wr(5, 8'h12); wr(7, 8'h7D);
    rd(3, 8'h30, "R2 minutes readback");
    rd(5, 8'h12, "R2 hours readback");
    rd(7, 8'h05, "R3 day bits 6..3 read zero");
    rd(4, 8'h00, "R3 non-alarm address reads zero");

    // R4 match without strobe does nothing
    @(posedge clk); #1;
    bus_sel = 0; cur_min = 8'h30; cur_hour = 8'h12; cur_day = 8'h05; sec_wrap = 0;
    idle(); #1 chk("R4 no strobe no flag", tod_flag, 0);
    tick(8'h30, 8'h12, 8'h05);
    idle(); #1 chk("R4 full match sets flag", tod_flag, 1);
    chk("R9 pin low when enabled", int_n, 0);
    irq_sel_wdog = 1; #1 chk("R9 switch to watchdog releases pin", int_n, 1);
    irq_sel_wdog = 0; tod_irq_mask = 1; #1 chk("R9 mask releases pin", int_n, 1);
    tod_irq_mask = 0;
    tick(8'h31, 8'h12, 8'h05);
    idle(); #1 chk("R7 flag sticky on mismatch strobe", tod_flag, 1);
    rd(4, 0, "R3 other read");
    idle(); #1 chk("R8 other address keeps flag", tod_flag, 1);
    rd(3, 8'h30, "R2 minutes readback");
    idle(); #1 chk("R8 read clears flag", tod_flag, 0);
    chk("R8 read releases pin", int_n, 1);

    // mismatch on day
    tick(8'h30, 8'h12, 8'h06);
    idle(); #1 chk("R4 day mismatch no flag", tod_flag, 0);

    // R6 ignored bits
    tick(8'hB0, 8'h92, 8'h0D);
    idle(); #1 chk("R6 high bits ignored still match", tod_flag, 1);
    wr(7, 8'h80);
    idle(); #1 chk("R8 write clears flag", tod_flag, 0);

    // R5 daily
    tick(8'h30, 8'h12, 8'h03);
    idle(); #1 chk("R5 daily any day", tod_flag, 1);
    rd(7, 8'h80, "R2 day readback");
    // R5 hourly
    wr(5, 8'h80);
    tick(8'h30, 8'h07, 8'h01);
    idle(); #1 chk("R5 hourly any hour", tod_flag, 1);
    wr(3, 8'h00);
    tick(8'h30, 8'h07, 8'h01);
    idle(); #1 chk("R5 hourly minute mismatch", tod_flag, 0);
    // R5 every minute
    wr(3, 8'h80);
    tick(8'h59, 8'h23, 8'h06);
    idle(); #1 chk("R5 every minute", tod_flag, 1);

    // R8 event and access in same cycle: event wins
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = 5; sec_wrap = 1;
    idle(); #1 chk("R8 event beats clear", tod_flag, 1);

    // Random phase, model compares each cycle
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      bus_sel  = ($urandom % 3) == 0;
      bus_wr   = $urandom % 2;
      bus_addr = 4'($urandom);
      bus_wdata = ($urandom % 2) ? 8'h80 : 8'($urandom % 4);
      cur_min  = 8'($urandom % 4) | (($urandom % 4 == 0) ? 8'h80 : 8'h00);
      cur_hour = 8'($urandom % 4);
      cur_day  = 8'($urandom % 16);
      sec_wrap = ($urandom % 3) == 0;
      irq_sel_wdog = ($urandom % 4) == 0;
      tod_irq_mask = ($urandom % 4) == 0;
    end
    idle(); idle();
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule